// File: doc/BRIEF.md
# Debug Line Break and Error Controller

This block watches a single-wire, open-drain, half-duplex debug serial line. It reacts to errors reported by the receiver and to clock-source changes by pulling the shared wire low for a fixed number of system clocks. This outgoing break tells the host to resynchronise. The same events abort the command in progress and restart baud measurement. The serial bit engine and the baud measurement logic sit outside. Only their status flags and reset pulses cross the boundary.

The block also recognises a break sent by the host: the wire stays low for longer than one character time. While such a break lasts, the debug logic is held in reset, and baud measurement gets a single reset pulse. Debug configuration and debug mode are not touched. Detection works while the local transmitter is sending, because any party can pull the wire low. The block's own break is never mistaken for a host break. Low time counts only from the moment the block lets go of the wire.

Top module: `dbg_break_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, line_pull_low, cmd_abort, abd_reset and dbg_reset are all 0.
- R2: A cycle with frame_err or tx_collision high makes cmd_abort high for the following cycle. cmd_abort is never high without such a cycle just before it.
- R3: A cycle with frame_err or tx_collision high makes line_pull_low rise in the following cycle. It stays high for exactly BREAK_CYCLES (default 4096) consecutive cycles.
- R4: Every error cycle, and every clock switch accepted under R5, makes abd_reset high for the following cycle.
- R5: clk_switch with abd_valid high starts the same outgoing break as R3 and pulses abd_reset, without cmd_abort. clk_switch with abd_valid low has no effect.
- R6: An error or accepted clock switch during an outgoing break restarts the count. line_pull_low then stays high for BREAK_CYCLES cycles after the last trigger.
- R7: A host break is detected when line_in is low and line_pull_low is low for more than T consecutive cycles. dbg_reset rises in cycle T+1 of the low run. T is 10 times abd_bit_clks while abd_valid is high, and MIN_LOW_CLKS (default 512) otherwise. A low run of T cycles or fewer has no effect.
- R8: dbg_reset stays high while line_in stays low. It falls in the cycle after the first high sample of line_in.
- R9: A host break detection pulses abd_reset once, in the cycle dbg_reset rises. It produces no cmd_abort and no line_pull_low.
- R10: A low line during the block's own break is never reported as a host break. A low that continues after release is timed from the first cycle with line_pull_low low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Sampled level of the shared debug wire |
| frame_err | input | 1 | Receiver framing error, one-cycle pulse |
| tx_collision | input | 1 | Transmit collision flag, one-cycle pulse |
| abd_valid | input | 1 | Baud measurement holds a valid rate |
| abd_bit_clks | input | BIT_W | Measured system clocks per bit |
| clk_switch | input | 1 | Clock-source switch detected, one-cycle pulse |
| line_pull_low | output | 1 | Drive the debug wire low (open-drain enable) |
| cmd_abort | output | 1 | Abort the command in progress, one-cycle pulse |
| abd_reset | output | 1 | Restart baud measurement, one-cycle pulse |
| dbg_reset | output | 1 | Hold debug logic in reset during a host break |

## Verification
The assertions take for granted that line_in is the wired-AND of every driver. Whenever line_pull_low is high, the sampled line is therefore low. They also assume that the error and clock-switch flags are single-cycle pulses, and that abd_bit_clks holds steady while a low run is being timed. The bench models the wire as the AND of the block's pull and a host pull, and raises each status flag for one cycle at a time. It changes the baud inputs only while the line is idle, and it extends a host break over the end of the block's own break to reach the R10 case.

// File: rtl/dbg_break_ctrl.sv
module dbg_break_ctrl #(
  parameter int BREAK_CYCLES = 4096,
  parameter int BIT_W        = 12,
  parameter int CHAR_BITS    = 10,
  parameter int MIN_LOW_CLKS = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             frame_err,
  input  logic             tx_collision,
  input  logic             abd_valid,
  input  logic [BIT_W-1:0] abd_bit_clks,
  input  logic             clk_switch,
  output logic             line_pull_low,
  output logic             cmd_abort,
  output logic             abd_reset,
  output logic             dbg_reset
);
  localparam int BRK_W = $clog2(BREAK_CYCLES + 1);
  localparam int LOW_W = BIT_W + $clog2(CHAR_BITS + 1) + 1;

  logic [BRK_W-1:0] brk_cnt;
  logic [LOW_W-1:0] low_cnt;
  logic [LOW_W-1:0] low_limit;
  logic             err, trig, low_seen, host_hit;

  assign err       = frame_err | tx_collision;
  assign trig      = err | (clk_switch & abd_valid);
  assign low_limit = abd_valid ? LOW_W'(abd_bit_clks) * LOW_W'(CHAR_BITS)
                               : LOW_W'(MIN_LOW_CLKS);
  assign low_seen  = !line_in && !line_pull_low;
  assign host_hit  = low_seen && (low_cnt >= low_limit) && !dbg_reset;

  assign line_pull_low = (brk_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      brk_cnt   <= '0;
      low_cnt   <= '0;
      cmd_abort <= 1'b0;
      abd_reset <= 1'b0;
      dbg_reset <= 1'b0;
    end else begin
      if (trig)
        brk_cnt <= BRK_W'(BREAK_CYCLES);
      else if (brk_cnt != '0)
        brk_cnt <= brk_cnt - 1'b1;

      if (!low_seen)
        low_cnt <= '0;
      else if (low_cnt < low_limit)
        low_cnt <= low_cnt + 1'b1;

      if (line_in)
        dbg_reset <= 1'b0;
      else if (host_hit)
        dbg_reset <= 1'b1;

      cmd_abort <= err;
      abd_reset <= trig | host_hit;
    end
  end
endmodule

module dbg_break_ctrl_chk #(
  parameter int BREAK_CYCLES = 4096,
  parameter int BIT_W        = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_in,
  input logic             frame_err,
  input logic             tx_collision,
  input logic             abd_valid,
  input logic [BIT_W-1:0] abd_bit_clks,
  input logic             clk_switch,
  input logic             line_pull_low,
  input logic             cmd_abort,
  input logic             abd_reset,
  input logic             dbg_reset
);
  logic err_i, trig_i;
  int   since_trig;

  assign err_i  = frame_err | tx_collision;
  assign trig_i = err_i | (clk_switch & abd_valid);

  always_ff @(posedge clk) begin
    if (!rst_n)             since_trig <= 0;
    else if (trig_i)        since_trig <= 0;
    else if (line_pull_low) since_trig <= since_trig + 1;
  end

  AST_ABORT_ON_ERR:   assert property (@(posedge clk) disable iff (!rst_n) err_i |=> cmd_abort);                   // R2
  AST_ABORT_ONLY_ERR: assert property (@(posedge clk) disable iff (!rst_n) !err_i |=> !cmd_abort);                 // R2
  AST_BREAK_START:    assert property (@(posedge clk) disable iff (!rst_n) err_i |=> line_pull_low);               // R3
  AST_BREAK_LEN:      assert property (@(posedge clk) disable iff (!rst_n) $fell(line_pull_low) |-> since_trig == BREAK_CYCLES); // R6
  AST_ABD_ON_TRIG:    assert property (@(posedge clk) disable iff (!rst_n) trig_i |=> abd_reset);                  // R4
  AST_SWITCH_GATED:   assert property (@(posedge clk) disable iff (!rst_n)
                        (clk_switch && !abd_valid && !err_i && !line_pull_low) |=> !line_pull_low);                 // R5
  AST_DETECT_LOW:     assert property (@(posedge clk) disable iff (!rst_n) $rose(dbg_reset) |-> $past(!line_in));  // R7
  AST_RELEASE:        assert property (@(posedge clk) disable iff (!rst_n) line_in |=> !dbg_reset);                // R8
  AST_DETECT_ABD:     assert property (@(posedge clk) disable iff (!rst_n) $rose(dbg_reset) |-> abd_reset);        // R9
  AST_NO_SELF_DETECT: assert property (@(posedge clk) disable iff (!rst_n) line_pull_low |=> !$rose(dbg_reset));   // R10
endmodule

bind dbg_break_ctrl dbg_break_ctrl_chk #(.BREAK_CYCLES(BREAK_CYCLES), .BIT_W(BIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_in(line_in), .frame_err(frame_err),
  .tx_collision(tx_collision), .abd_valid(abd_valid), .abd_bit_clks(abd_bit_clks),
  .clk_switch(clk_switch), .line_pull_low(line_pull_low), .cmd_abort(cmd_abort),
  .abd_reset(abd_reset), .dbg_reset(dbg_reset)
);

// File: tb/dbg_break_ctrl_tb.sv
module dbg_break_ctrl_tb;
  localparam int BRK = 4096;
  localparam int MINLOW = 512;

  typedef enum int {EV_PULL_RISE, EV_PULL_FALL, EV_ABORT, EV_ABD, EV_DBG_RISE, EV_DBG_FALL} ev_e;
  typedef struct {int cyc; ev_e kind; string req;} item_t;

  logic clk = 0, rst_n = 0, host_low = 0;
  logic frame_err = 0, tx_collision = 0, abd_valid = 0, clk_switch = 0;
  logic [11:0] abd_bit_clks = 12'd8;
  logic line_in, line_pull_low, cmd_abort, abd_reset, dbg_reset;
  int cyc = 0, checks = 0, failures = 0;
  logic mon_on = 0, prev_pull = 0, prev_dbg = 0;
  item_t exp_q[$];

  assign line_in = !(host_low || line_pull_low);

  dbg_break_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .frame_err(frame_err),
    .tx_collision(tx_collision), .abd_valid(abd_valid), .abd_bit_clks(abd_bit_clks),
    .clk_switch(clk_switch), .line_pull_low(line_pull_low), .cmd_abort(cmd_abort),
    .abd_reset(abd_reset), .dbg_reset(dbg_reset)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_ev(input int c, input ev_e k, input string r);
    item_t it;
    it.cyc = c; it.kind = k; it.req = r;
    exp_q.push_back(it);
  endtask

  task automatic observe(input ev_e k);
    item_t it;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL R5 R9 R10 unexpected event: actual=%s@%0d expected=none", k.name(), cyc);
    end else begin
      it = exp_q.pop_front();
      if (it.kind != k || it.cyc != cyc) begin
        failures++;
        $display("FAIL %s actual=%s@%0d expected=%s@%0d", it.req, k.name(), cyc, it.kind.name(), it.cyc);
      end
    end
  endtask

  task automatic chk(input logic ok, input string r, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (line_pull_low && !prev_pull) observe(EV_PULL_RISE);
      if (!line_pull_low && prev_pull) observe(EV_PULL_FALL);
      if (cmd_abort) observe(EV_ABORT);
      if (abd_reset) observe(EV_ABD);
      if (dbg_reset && !prev_dbg) observe(EV_DBG_RISE);
      if (!dbg_reset && prev_dbg) observe(EV_DBG_FALL);
    end
    prev_pull = line_pull_low;
    prev_dbg  = dbg_reset;
  end

  // Driver: one-cycle trigger pulse, pushes the expected consequences.
  task automatic fire(input bit fe, input bit co, input bit sw, input bit in_brk, output int c);
    @(negedge clk);
    c = cyc;
    frame_err = fe; tx_collision = co; clk_switch = sw;
    if ((fe || co || (sw && abd_valid)) && !in_brk) expect_ev(c + 1, EV_PULL_RISE, "R3 R5");
    if (fe || co) expect_ev(c + 1, EV_ABORT, "R2");
    if (fe || co || (sw && abd_valid)) expect_ev(c + 1, EV_ABD, "R4");
    @(negedge clk);
    frame_err = 0; tx_collision = 0; clk_switch = 0;
  endtask

  task automatic host_break(input int limit, input int hold);
    int c;
    @(negedge clk);
    c = cyc;
    host_low = 1;
    if (hold > limit) begin
      expect_ev(c + limit + 1, EV_ABD, "R9");
      expect_ev(c + limit + 1, EV_DBG_RISE, "R7");
    end
    repeat (hold) @(negedge clk);
    host_low = 0;
    if (hold > limit) expect_ev(c + hold + 1, EV_DBG_FALL, "R8");
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c, c2;
    repeat (4) @(negedge clk);
    chk({line_pull_low, cmd_abort, abd_reset, dbg_reset} == 4'b0, "R1 in reset",
        {line_pull_low, cmd_abort, abd_reset, dbg_reset}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({line_pull_low, cmd_abort, abd_reset, dbg_reset} == 4'b0, "R1 after release",
        {line_pull_low, cmd_abort, abd_reset, dbg_reset}, 0);
    mon_on = 1;

    // R2 R3 R4: framing error
    fire(1, 0, 0, 0, c);
    expect_ev(c + 1 + BRK, EV_PULL_FALL, "R3");
    repeat (BRK + 20) @(negedge clk);

    // R2 R3: collision
    fire(0, 1, 0, 0, c);
    expect_ev(c + 1 + BRK, EV_PULL_FALL, "R3");
    repeat (BRK + 20) @(negedge clk);

    // R5: clock switch with valid baud
    abd_valid = 1;
    fire(0, 0, 1, 0, c);
    expect_ev(c + 1 + BRK, EV_PULL_FALL, "R5");
    repeat (BRK + 20) @(negedge clk);

    // R5: clock switch without valid baud is ignored
    abd_valid = 0;
    fire(0, 0, 1, 0, c);
    repeat (40) @(negedge clk);
    chk(line_pull_low == 0, "R5 ignored switch", line_pull_low, 0);

    // R6: retrigger restarts the break count
    fire(1, 0, 0, 0, c);
    repeat (998) @(negedge clk);
    fire(1, 0, 0, 1, c2);
    chk(c2 == c + 1000, "R6 retrigger spacing", c2, c + 1000);
    expect_ev(c2 + 1 + BRK, EV_PULL_FALL, "R6");
    repeat (BRK + 20) @(negedge clk);

    // R7 R8 R9: host break, valid baud, limit 10*8
    abd_valid = 1;
    abd_bit_clks = 12'd8;
    host_break(80, 200);
    // R7: a low run of exactly the limit is not a break
    host_break(80, 80);
    chk(dbg_reset == 0, "R7 short low", dbg_reset, 0);
    // R7: invalid baud uses the fixed minimum
    abd_valid = 0;
    host_break(MINLOW, 600);
    abd_valid = 1;

    // R10: host low during own break, extended past release
    fire(1, 0, 0, 0, c);
    expect_ev(c + 1 + BRK, EV_PULL_FALL, "R10");
    repeat (100) @(negedge clk);
    host_low = 1;
    expect_ev(c + BRK + 2 + 80, EV_ABD, "R10");
    expect_ev(c + BRK + 2 + 80, EV_DBG_RISE, "R10");
    while (cyc < c + BRK + 204) @(negedge clk);
    host_low = 0;
    expect_ev(c + BRK + 205, EV_DBG_FALL, "R8");
    repeat (30) @(negedge clk);

    chk(exp_q.size() == 0, "R2 R3 R7 R10 missing events", exp_q.size(), 0);
    while (exp_q.size() != 0) begin
      item_t it;
      it = exp_q.pop_front();
      $display("FAIL %s actual=none expected=%s@%0d", it.req, it.kind.name(), it.cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule